// File: doc/BRIEF.md
# Multi-Region Crossbar Address Decoder

This block sits at the front of a crossbar's address path. It takes the address of an incoming transaction and decides which output port receives it, and which of that port's address windows the address falls in. Each output port owns a fixed number of windows. Each window is described by two parameters: a base value, and a span exponent that gives its size as a power of two. A window qualifies only when three more conditions hold: the connectivity mask allows the requesting input to reach that port in the current direction, the port's security rule accepts the access, and the window is enabled.

A one-cycle start strobe captures the inputs. On the next clock edge the outcome appears on registered outputs: a hit flag, the port index and the window index. The outcome stays there until the next strobe. When the hit flag is low, the caller returns a decode error. A constant output reports a mis-built parameter set, meaning an enabled window whose base is not aligned to its own size. At simulation start the block also prints a note for every pair of windows on different ports that overlap.

Top module: `xbar_addr_decode`

## Requirements
- R1: While reset is asserted and right after it is released, `hit`, `port_sel` and `rgn_sel` are all zero.
- R2: Window (p,r) matches address A when its span exponent W is nonzero and A shifted right by W equals its base shifted right by W. A span of W at or above the address width covers every address. Window fields are packed at index p*RGN_CNT+r: 32 bits each for spans, ADDR_W bits each for bases.
- R3: A window whose span exponent is zero is disabled and never matches, even when its base equals the address.
- R4: When an output port's bit in PORT_SECURE is 1, the port rejects any access presented with `nonsec`=1. The same port accepts the access when `nonsec`=0.
- R5: A match also requires bit (src_idx + p*IN_CNT) of the connectivity mask to be 1. CONN_RD is used when `is_write`=0 and CONN_WR when `is_write`=1.
- R6: When no qualifying window exists, `hit` is 0 and `port_sel` and `rgn_sel` are both 0.
- R7: When several windows qualify, the highest port index wins. Within that port, the highest window index wins.
- R8: The outcome appears on the outputs at the first clock edge after the edge that samples `start`=1. It then holds unchanged, whatever the other inputs do, until the next accepted start.
- R9: `cfg_bad` is 1 exactly when some enabled window has a base with a nonzero bit below its span exponent. A span at or above the address width counts as misaligned unless the base is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that samples the request |
| addr | input | ADDR_W | Transaction address |
| nonsec | input | 1 | Protection bit 1 of the request; 1 marks a non-secure access |
| src_idx | input | SRC_W | Index of the requesting input port |
| is_write | input | 1 | 1 selects the write connectivity mask, 0 the read mask |
| port_sel | output | PORT_W | Selected output port, registered |
| rgn_sel | output | RGN_W | Selected window within the port, registered |
| hit | output | 1 | 1 when a qualifying window was found, registered |
| cfg_bad | output | 1 | Parameter set contains a misaligned enabled window |

## Verification
The main configuration is swept over every 256-byte address step. Each step is tried with both protection values, both inputs and both directions. This separates the span arithmetic from the security rule and the per-direction connectivity mask, since each of those can turn a hit into a miss on its own. Directed requests go to addresses covered by two windows, one pair on the same port and one pair on different ports. These show the priority order, and one of them lands on a disabled window whose base would otherwise match. A hold sequence changes the inputs without a strobe to separate the capture from pass-through. A second instance built with a deliberately misaligned window checks the configuration flag in both polarities.

// File: rtl/xad_pkg.sv
package xad_pkg;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // True when an enabled window's base has bits below its span exponent.
  function automatic logic base_misaligned(input logic [63:0] base, input int unsigned bits,
                                           input int unsigned aw);
    logic [63:0] low_mask;
    if (bits == 0) return 1'b0;
    if (bits >= aw) return (base != 64'd0);
    low_mask = (64'd1 << bits) - 64'd1;
    return ((base & low_mask) != 64'd0);
  endfunction

endpackage

// File: rtl/xad_region_match.sv
module xad_region_match #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_VAL = '0,
  parameter int unsigned SPAN_EXP = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              misaligned
);
  import xad_pkg::*;

  localparam logic MISALIGNED = base_misaligned(64'(BASE_VAL), SPAN_EXP, ADDR_W);

  generate
    if (SPAN_EXP == 0) begin : g_off
      assign hit = 1'b0;
    end else if (SPAN_EXP >= ADDR_W) begin : g_all
      assign hit = 1'b1;
    end else begin : g_cmp
      assign hit = (addr[ADDR_W-1:SPAN_EXP] == BASE_VAL[ADDR_W-1:SPAN_EXP]);
    end
  endgenerate

  assign misaligned = MISALIGNED;

endmodule

// File: rtl/xad_pick.sv
module xad_pick #(
  parameter int OUT_CNT = 3,
  parameter int RGN_CNT = 2,
  parameter int PORT_W  = 2,
  parameter int RGN_W   = 1
) (
  input  logic [OUT_CNT*RGN_CNT-1:0] win_hit,
  input  logic [OUT_CNT-1:0]         port_ok,
  output logic                       found,
  output logic [PORT_W-1:0]          port_idx,
  output logic [RGN_W-1:0]           rgn_idx
);
  // Ascending scan; a later hit overwrites an earlier one, so the
  // highest port, then the highest window, takes precedence.
  always_comb begin
    found    = 1'b0;
    port_idx = '0;
    rgn_idx  = '0;
    for (int p = 0; p < OUT_CNT; p++) begin
      for (int r = 0; r < RGN_CNT; r++) begin
        if (port_ok[p] && win_hit[p*RGN_CNT+r]) begin
          found    = 1'b1;
          port_idx = PORT_W'(p);
          rgn_idx  = RGN_W'(r);
        end
      end
    end
  end

endmodule

// File: rtl/xbar_addr_decode.sv
module xbar_addr_decode #(
  parameter int ADDR_W  = 16,
  parameter int IN_CNT  = 2,
  parameter int OUT_CNT = 3,
  parameter int RGN_CNT = 2,
  parameter logic [OUT_CNT*RGN_CNT*ADDR_W-1:0] RGN_BASE =
    {16'h1000, 16'h6000, 16'h4800, 16'h4000, 16'h1000, 16'h0000},
  parameter logic [OUT_CNT*RGN_CNT*32-1:0] RGN_SPAN =
    {32'd0, 32'd13, 32'd11, 32'd14, 32'd12, 32'd12},
  parameter logic [IN_CNT*OUT_CNT-1:0] CONN_RD = 6'b111111,
  parameter logic [IN_CNT*OUT_CNT-1:0] CONN_WR = 6'b111101,
  parameter logic [OUT_CNT-1:0] PORT_SECURE = 3'b010,
  localparam int SRC_W  = xad_pkg::idx_w(IN_CNT),
  localparam int PORT_W = xad_pkg::idx_w(OUT_CNT),
  localparam int RGN_W  = xad_pkg::idx_w(RGN_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              nonsec,
  input  logic [SRC_W-1:0]  src_idx,
  input  logic              is_write,
  output logic [PORT_W-1:0] port_sel,
  output logic [RGN_W-1:0]  rgn_sel,
  output logic              hit,
  output logic              cfg_bad
);
  localparam int WIN_CNT = OUT_CNT * RGN_CNT;

  logic [WIN_CNT-1:0] win_hit;
  logic [WIN_CNT-1:0] win_bad;
  logic [OUT_CNT-1:0] port_ok;
  logic               found_c;
  logic [PORT_W-1:0]  port_c;
  logic [RGN_W-1:0]   rgn_c;
  logic               hit_q;
  logic [PORT_W-1:0]  port_q;
  logic [RGN_W-1:0]   rgn_q;

  // One comparator per window.
  for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
    xad_region_match #(
      .ADDR_W  (ADDR_W),
      .BASE_VAL(RGN_BASE[w*ADDR_W +: ADDR_W]),
      .SPAN_EXP(RGN_SPAN[w*32 +: 32])
    ) i_match (
      .addr      (addr),
      .hit       (win_hit[w]),
      .misaligned(win_bad[w])
    );
  end

  // Per-port qualification: connectivity row and security rule.
  for (genvar p = 0; p < OUT_CNT; p++) begin : g_port
    localparam logic [IN_CNT-1:0] RD_ROW = CONN_RD[p*IN_CNT +: IN_CNT];
    localparam logic [IN_CNT-1:0] WR_ROW = CONN_WR[p*IN_CNT +: IN_CNT];
    logic conn_ok;
    assign conn_ok    = is_write ? WR_ROW[src_idx] : RD_ROW[src_idx];
    assign port_ok[p] = conn_ok && !(PORT_SECURE[p] && nonsec);
  end

  xad_pick #(
    .OUT_CNT(OUT_CNT),
    .RGN_CNT(RGN_CNT),
    .PORT_W (PORT_W),
    .RGN_W  (RGN_W)
  ) i_pick (
    .win_hit (win_hit),
    .port_ok (port_ok),
    .found   (found_c),
    .port_idx(port_c),
    .rgn_idx (rgn_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      port_q <= '0;
      rgn_q  <= '0;
    end else if (start) begin
      hit_q  <= found_c;
      port_q <= port_c;
      rgn_q  <= rgn_c;
    end
  end

  assign hit      = hit_q;
  assign port_sel = port_q;
  assign rgn_sel  = rgn_q;
  assign cfg_bad  = |win_bad;

  // Start-of-simulation report of windows on different ports that overlap.
  initial begin
    for (int a = 0; a < WIN_CNT; a++) begin
      for (int b = a + 1; b < WIN_CNT; b++) begin
        int unsigned sa, sb, sm;
        logic [ADDR_W-1:0] ba, bb;
        logic ov;
        sa = RGN_SPAN[a*32 +: 32];
        sb = RGN_SPAN[b*32 +: 32];
        ba = RGN_BASE[a*ADDR_W +: ADDR_W];
        bb = RGN_BASE[b*ADDR_W +: ADDR_W];
        ov = 1'b0;
        if ((a / RGN_CNT) != (b / RGN_CNT) && sa != 0 && sb != 0) begin
          sm = (sa > sb) ? sa : sb;
          if (sm >= ADDR_W) ov = 1'b1;
          else ov = ((ba >> sm) == (bb >> sm));
        end
        if (ov)
          $display("xbar_addr_decode note: window %0d/%0d overlaps window %0d/%0d",
                   a / RGN_CNT, a % RGN_CNT, b / RGN_CNT, b % RGN_CNT);
      end
    end
  end

  // Outcome holds when no start was sampled.
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable({hit, port_sel, rgn_sel}));

  // A miss leaves both indices at zero.
  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (port_sel == '0 && rgn_sel == '0));

  // A non-secure request never lands on a secure port.
  assert_secure_R4: assert property (@(posedge clk) disable iff (rst)
    (start && nonsec) |=> !(hit && (((PORT_SECURE >> port_sel) & 1) != 0)));

  // A hit always has its connectivity bit set for the captured direction.
  assert_conn_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> (!hit ||
      (((($past(is_write) ? CONN_WR : CONN_RD) >>
         (int'($past(src_idx)) + int'(port_sel) * IN_CNT)) & 1) != 0)));

endmodule

// File: tb/test_xbar_addr_decode.sv
module test_xbar_addr_decode;
  localparam int AW = 16;
  localparam int NI = 2;
  localparam int NO = 3;
  localparam int NR = 2;
  localparam logic [NO*NR*AW-1:0] BASES =
    {16'h1000, 16'h6000, 16'h4800, 16'h4000, 16'h1000, 16'h0000};
  localparam logic [NO*NR*32-1:0] SPANS =
    {32'd0, 32'd13, 32'd11, 32'd14, 32'd12, 32'd12};
  localparam logic [NI*NO-1:0] CRD = 6'b111111;
  localparam logic [NI*NO-1:0] CWR = 6'b111101;
  localparam logic [NO-1:0]    SEC = 3'b010;
  localparam logic [NO*NR*AW-1:0] BAD_BASES =
    {16'h1000, 16'h6000, 16'h4800, 16'h4000, 16'h1000, 16'h1000};
  localparam logic [NO*NR*32-1:0] BAD_SPANS =
    {32'd0, 32'd13, 32'd11, 32'd14, 32'd12, 32'd16};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic nonsec = 1'b0;
  logic src_idx = 1'b0;
  logic is_write = 1'b0;
  logic [1:0] port_sel;
  logic rgn_sel;
  logic hit;
  logic cfg_bad;
  logic [1:0] b_port;
  logic b_rgn, b_hit, b_cfg;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xbar_addr_decode #(
    .ADDR_W(AW), .IN_CNT(NI), .OUT_CNT(NO), .RGN_CNT(NR),
    .RGN_BASE(BASES), .RGN_SPAN(SPANS),
    .CONN_RD(CRD), .CONN_WR(CWR), .PORT_SECURE(SEC)
  ) i_xbar_addr_decode (
    .clk(clk), .rst(rst), .start(start), .addr(addr), .nonsec(nonsec),
    .src_idx(src_idx), .is_write(is_write),
    .port_sel(port_sel), .rgn_sel(rgn_sel), .hit(hit), .cfg_bad(cfg_bad)
  );

  xbar_addr_decode #(
    .ADDR_W(AW), .IN_CNT(NI), .OUT_CNT(NO), .RGN_CNT(NR),
    .RGN_BASE(BAD_BASES), .RGN_SPAN(BAD_SPANS),
    .CONN_RD(CRD), .CONN_WR(CWR), .PORT_SECURE(SEC)
  ) i_xbar_addr_decode_bad (
    .clk(clk), .rst(rst), .start(start), .addr(addr), .nonsec(nonsec),
    .src_idx(src_idx), .is_write(is_write),
    .port_sel(b_port), .rgn_sel(b_rgn), .hit(b_hit), .cfg_bad(b_cfg)
  );

  // Expected outcome from the requirement text (R2..R7).
  task automatic expect_of(input logic [AW-1:0] a, input logic ns, input int s,
                           input logic w, output logic eh, output int ep, output int er);
    eh = 1'b0; ep = 0; er = 0;
    for (int p = 0; p < NO; p++) begin
      for (int r = 0; r < NR; r++) begin
        int unsigned sp;
        logic [AW-1:0] bs;
        logic m, c;
        sp = SPANS[(p*NR+r)*32 +: 32];
        bs = BASES[(p*NR+r)*AW +: AW];
        m  = (sp != 0) && ((sp >= AW) || ((a >> sp) == (bs >> sp)));
        c  = w ? CWR[s + p*NI] : CRD[s + p*NI];
        if (m && c && !(SEC[p] && ns)) begin
          eh = 1'b1; ep = p; er = r;
        end
      end
    end
  endtask

  task automatic decode(input logic [AW-1:0] a, input logic ns, input logic s, input logic w);
    @(negedge clk);
    addr = a; nonsec = ns; src_idx = s; is_write = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check(input string tag, input logic eh, input int ep, input int er);
    checks++;
    if (hit !== eh || int'(port_sel) != ep || int'(rgn_sel) != er) begin
      errors++;
      $display("FAIL %s: got hit=%0b port=%0d rgn=%0d, expected hit=%0b port=%0d rgn=%0d",
               tag, hit, port_sel, rgn_sel, eh, ep, er);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b, expected %0b", tag, got, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 1'b0, 0, 0);
    check_bit("R9 aligned config", cfg_bad, 1'b0);
    check_bit("R9 misaligned config", b_cfg, 1'b1);

    // R2 plain matches
    decode(16'h0123, 1'b0, 1'b0, 1'b0); check("R2 port0 win0", 1'b1, 0, 0);
    decode(16'h4100, 1'b0, 1'b0, 1'b0); check("R2 port1 win0", 1'b1, 1, 0);
    // R3: disabled port2 win1 has base 0x1000 but must not take it
    decode(16'h1FFF, 1'b0, 1'b0, 1'b0); check("R3 disabled window", 1'b1, 0, 1);
    // R7 same-port and cross-port priority
    decode(16'h4900, 1'b0, 1'b0, 1'b0); check("R7 higher window", 1'b1, 1, 1);
    decode(16'h6100, 1'b0, 1'b0, 1'b0); check("R7 higher port", 1'b1, 2, 0);
    // R4 secure port
    decode(16'h4100, 1'b1, 1'b0, 1'b0); check("R4 nonsec rejected", 1'b0, 0, 0);
    decode(16'h4900, 1'b1, 1'b1, 1'b1); check("R4 nonsec rejected win1", 1'b0, 0, 0);
    decode(16'h6100, 1'b1, 1'b0, 1'b0); check("R4 open port accepts", 1'b1, 2, 0);
    // R5 connectivity per direction
    decode(16'h0123, 1'b0, 1'b1, 1'b1); check("R5 write blocked src1", 1'b0, 0, 0);
    decode(16'h0123, 1'b0, 1'b1, 1'b0); check("R5 read allowed src1", 1'b1, 0, 0);
    decode(16'h0123, 1'b0, 1'b0, 1'b1); check("R5 write allowed src0", 1'b1, 0, 0);
    // R6 miss after a hit
    decode(16'h4900, 1'b0, 1'b0, 1'b0);
    decode(16'h2000, 1'b0, 1'b0, 1'b0); check("R6 unmapped", 1'b0, 0, 0);
    decode(16'hC000, 1'b0, 1'b0, 1'b0); check("R6 unmapped high", 1'b0, 0, 0);
    // R8 hold without start
    decode(16'h4900, 1'b0, 1'b0, 1'b0); check("R8 captured", 1'b1, 1, 1);
    addr = 16'h0000; nonsec = 1'b1; is_write = 1'b1; src_idx = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 held", 1'b1, 1, 1);

    // Sweep for R2, R4, R5, R7
    for (int a = 0; a < 65536; a += 256) begin
      for (int v = 0; v < 8; v++) begin
        logic eh;
        int ep, er;
        expect_of(AW'(a), v[0], int'(v[1]), v[2], eh, ep, er);
        decode(AW'(a), v[0], v[1], v[2]);
        check("R2 sweep", eh, ep, er);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule